// File: doc/BRIEF.md
# Cascaded Match and Full Flag Chain

This block is the per-device flag logic that lets several associative-memory devices be stacked in a vertical chain with no glue between them. Each device takes the match and full flags of the device above it, merges them with its own local state and passes the result to the device below. All chain flags are active low. The first device has its match input tied high and its full input tied low. The last device's outputs act as the system-wide match and full flags.

From the chain flags the block decides which single device owns the highest-priority match and which owns the next free slot. Only those devices are granted operations aimed at them. Two enable bits can make a device transparent, so that its output simply follows its input. A page address compare decides whether a bus access targets this device, and an all-ones device-select value reaches every device, but for writes only. Switching the active configuration register set clears every match indication.

Top module: `casc_flag_chain`

## Requirements
- R1: While reset is asserted, and after it until the first cycle end, `match_out_n` is 1 and `full_out_n` equals `full_in_n`.
- R2: At each rising clock with `cyc_start` high, `chain_en_n` is captured. At a rising clock with `cyc_end` high and no `set_switch`, `match_out_n` is loaded with 1 if the last captured `chain_en_n` was 1.
- R3: At a cycle end with the chain enabled and `mf_enable`=1, `match_out_n` becomes 0 exactly when the held local hit is 1 or `match_in_n` is 0.
- R4: With `mf_enable`=0, a cycle end with the chain enabled loads `match_out_n` with `match_in_n`, and `hp_grant` stays 0.
- R5: With `ff_enable`=1, a cycle end loads `full_out_n` with 0 exactly when `loc_full` is 1 and `full_in_n` is 0.
- R6: With `ff_enable`=0, a cycle end loads `full_out_n` with `full_in_n`, and both `nf_grant` and `page_wr_grant` stay 0.
- R7: `nf_grant` = `nf_req` AND `ff_enable` AND NOT `full_in_n` AND NOT `loc_full`, i.e. full above and room here.
- R8: `hp_grant` = `hp_req` AND `mf_enable` AND held hit AND `match_in_n`, i.e. a local match with no match above.
- R9: `sel_hit` is 1 when `dev_sel` equals `page_addr`, or when `dev_sel` is all ones and `wr_op` is 1. `page_wr_grant` = `page_wr_req` AND `sel_hit` AND `ff_enable`.
- R10: A rising clock with `set_switch` high clears the held hit and sets `match_out_n` to 1. This takes priority over `cmp_valid` and `cyc_end` in the same cycle.
- R11: The held hit is loaded from `cmp_hit` at a rising clock with `cmp_valid` high, and is otherwise kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cyc_start | input | 1 | First clock of a bus cycle; captures chain enable |
| cyc_end | input | 1 | Last clock of a bus cycle; updates chain outputs |
| chain_en_n | input | 1 | Active-low chain enable strobe |
| cmp_valid | input | 1 | Compare result available |
| cmp_hit | input | 1 | Local compare found a valid match |
| set_switch | input | 1 | Active configuration set changed |
| loc_full | input | 1 | No empty entry in this device |
| match_in_n | input | 1 | Match flag from the device above |
| full_in_n | input | 1 | Full flag from the device above |
| mf_enable | input | 1 | Local match flag enable |
| ff_enable | input | 1 | Local full flag enable |
| page_addr | input | PAGE_W | This device's page address |
| dev_sel | input | PAGE_W | Device select value |
| wr_op | input | 1 | Current access is a write |
| hp_req | input | 1 | Operation aimed at the highest-priority match |
| nf_req | input | 1 | Operation aimed at the next free slot |
| page_wr_req | input | 1 | Write to the page address |
| match_out_n | output | 1 | Match flag to the device below |
| full_out_n | output | 1 | Full flag to the device below |
| sel_hit | output | 1 | This device is selected |
| hp_grant | output | 1 | Highest-priority operation granted here |
| nf_grant | output | 1 | Next-free operation granted here |
| page_wr_grant | output | 1 | Page address write granted |

## Verification
The hardest state to reach is a low `match_out_n` driven by this device's own hit. To get there, a compare must leave a hit, a cycle start must capture a low enable, and a cycle end must follow, with no set switch in between. The random stimulus strobes compares, starts and ends often and switches sets rarely, so these orderings occur many times. Directed steps then force a set switch in the same clock as a compare and a cycle end, and drive an all-ones select on reads and on writes.

// File: rtl/cfc_pkg.sv
package cfc_pkg;
  localparam int unsigned CFC_PAGE_W = 16;

  // active-low merge of local hit with upstream match
  function automatic logic merge_match_n(input logic hit, input logic up_n);
    return ~(hit | ~up_n);
  endfunction

  // active-low full: low only when both local and upstream are full
  function automatic logic merge_full_n(input logic full, input logic up_n);
    return ~(full & ~up_n);
  endfunction
endpackage

// File: rtl/cfc_match_stage.sv
module cfc_match_stage (
  input  logic clk,
  input  logic rst_n,
  input  logic cyc_start,
  input  logic cyc_end,
  input  logic chain_en_n,
  input  logic cmp_valid,
  input  logic cmp_hit,
  input  logic set_switch,
  input  logic mf_enable,
  input  logic match_in_n,
  output logic match_out_n,
  output logic hit_held,
  output logic chain_on
);
  import cfc_pkg::*;

  logic hit_q, hit_d;
  logic on_q, on_d;
  logic mo_q, mo_d;

  always_comb begin
    on_d = on_q;
    if (cyc_start) on_d = ~chain_en_n;

    hit_d = hit_q;
    if (set_switch)     hit_d = 1'b0;
    else if (cmp_valid) hit_d = cmp_hit;

    mo_d = mo_q;
    if (set_switch) begin
      mo_d = 1'b1;
    end else if (cyc_end) begin
      if (!on_q)          mo_d = 1'b1;
      else if (mf_enable) mo_d = merge_match_n(hit_q, match_in_n);
      else                mo_d = match_in_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hit_q <= 1'b0;
      on_q  <= 1'b0;
      mo_q  <= 1'b1;
    end else begin
      hit_q <= hit_d;
      on_q  <= on_d;
      mo_q  <= mo_d;
    end
  end

  assign match_out_n = mo_q;
  assign hit_held    = hit_q;
  assign chain_on    = on_q;
endmodule

// File: rtl/cfc_full_stage.sv
module cfc_full_stage (
  input  logic clk,
  input  logic rst_n,
  input  logic cyc_end,
  input  logic loc_full,
  input  logic full_in_n,
  input  logic ff_enable,
  output logic full_out_n,
  output logic nf_owner
);
  import cfc_pkg::*;

  logic fo_q, fo_d;
  logic live_q, live_d;

  always_comb begin
    fo_d   = fo_q;
    live_d = live_q;
    if (cyc_end) begin
      live_d = 1'b1;
      fo_d   = ff_enable ? merge_full_n(loc_full, full_in_n) : full_in_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fo_q   <= 1'b1;
      live_q <= 1'b0;
    end else begin
      fo_q   <= fo_d;
      live_q <= live_d;
    end
  end

  // until the first cycle end the device is transparent
  assign full_out_n = live_q ? fo_q : full_in_n;
  assign nf_owner   = ff_enable & ~full_in_n & ~loc_full;
endmodule

// File: rtl/cfc_dev_select.sv
module cfc_dev_select #(
  parameter int unsigned PAGE_W   = 16,
  parameter bit          BCAST_EN = 1'b1
) (
  input  logic [PAGE_W-1:0] page_addr,
  input  logic [PAGE_W-1:0] dev_sel,
  input  logic              wr_op,
  output logic              sel_hit
);
  localparam logic [PAGE_W-1:0] ALL_DEV = {PAGE_W{1'b1}};

  logic own_hit;
  assign own_hit = (dev_sel == page_addr);

  generate
    if (BCAST_EN) begin : g_bcast
      assign sel_hit = own_hit | (wr_op & (dev_sel == ALL_DEV));
    end else begin : g_nobcast
      assign sel_hit = own_hit;
    end
  endgenerate
endmodule

// File: rtl/casc_flag_chain.sv
module casc_flag_chain #(
  parameter int unsigned PAGE_W = cfc_pkg::CFC_PAGE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cyc_start,
  input  logic              cyc_end,
  input  logic              chain_en_n,
  input  logic              cmp_valid,
  input  logic              cmp_hit,
  input  logic              set_switch,
  input  logic              loc_full,
  input  logic              match_in_n,
  input  logic              full_in_n,
  input  logic              mf_enable,
  input  logic              ff_enable,
  input  logic [PAGE_W-1:0] page_addr,
  input  logic [PAGE_W-1:0] dev_sel,
  input  logic              wr_op,
  input  logic              hp_req,
  input  logic              nf_req,
  input  logic              page_wr_req,
  output logic              match_out_n,
  output logic              full_out_n,
  output logic              sel_hit,
  output logic              hp_grant,
  output logic              nf_grant,
  output logic              page_wr_grant
);
  logic hit_held;
  logic chain_on;
  logic nf_owner;

  cfc_match_stage u_match (
    .clk         (clk),
    .rst_n       (rst_n),
    .cyc_start   (cyc_start),
    .cyc_end     (cyc_end),
    .chain_en_n  (chain_en_n),
    .cmp_valid   (cmp_valid),
    .cmp_hit     (cmp_hit),
    .set_switch  (set_switch),
    .mf_enable   (mf_enable),
    .match_in_n  (match_in_n),
    .match_out_n (match_out_n),
    .hit_held    (hit_held),
    .chain_on    (chain_on)
  );

  cfc_full_stage u_full (
    .clk        (clk),
    .rst_n      (rst_n),
    .cyc_end    (cyc_end),
    .loc_full   (loc_full),
    .full_in_n  (full_in_n),
    .ff_enable  (ff_enable),
    .full_out_n (full_out_n),
    .nf_owner   (nf_owner)
  );

  cfc_dev_select #(.PAGE_W(PAGE_W), .BCAST_EN(1'b1)) u_sel (
    .page_addr (page_addr),
    .dev_sel   (dev_sel),
    .wr_op     (wr_op),
    .sel_hit   (sel_hit)
  );

  assign hp_grant      = hp_req & mf_enable & hit_held & match_in_n;
  assign nf_grant      = nf_req & nf_owner;
  assign page_wr_grant = page_wr_req & sel_hit & ff_enable;
endmodule

// File: rtl/cfc_checker.sv
module cfc_checker (
  input logic clk,
  input logic rst_n,
  input logic cyc_end,
  input logic set_switch,
  input logic chain_on,
  input logic mf_enable,
  input logic ff_enable,
  input logic match_in_n,
  input logic full_in_n,
  input logic match_out_n,
  input logic full_out_n,
  input logic hp_grant,
  input logic nf_grant,
  input logic page_wr_grant
);
  assert_chain_off_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_end && !chain_on && !set_switch) |=> match_out_n);

  assert_mf_transparent_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_end && chain_on && !mf_enable && !set_switch) |=> (match_out_n == $past(match_in_n)));

  assert_no_hp_grant_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !mf_enable |-> !hp_grant);

  assert_ff_transparent_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_end && !ff_enable) |=> (full_out_n == $past(full_in_n)));

  assert_ff_off_grants_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !ff_enable |-> (!nf_grant && !page_wr_grant));

  assert_nf_needs_full_above_R7: assert property (@(posedge clk) disable iff (!rst_n)
    nf_grant |-> !full_in_n);

  assert_hp_top_R8: assert property (@(posedge clk) disable iff (!rst_n)
    hp_grant |-> match_in_n);

  assert_switch_clears_R10: assert property (@(posedge clk) disable iff (!rst_n)
    set_switch |=> (match_out_n && !hp_grant));
endmodule

bind casc_flag_chain cfc_checker u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .cyc_end       (cyc_end),
  .set_switch    (set_switch),
  .chain_on      (chain_on),
  .mf_enable     (mf_enable),
  .ff_enable     (ff_enable),
  .match_in_n    (match_in_n),
  .full_in_n     (full_in_n),
  .match_out_n   (match_out_n),
  .full_out_n    (full_out_n),
  .hp_grant      (hp_grant),
  .nf_grant      (nf_grant),
  .page_wr_grant (page_wr_grant)
);

// File: tb/casc_flag_chain_tb.sv
module casc_flag_chain_tb;
  localparam int W = 16;

  logic clk = 1'b0;
  logic rst_n;
  logic cyc_start, cyc_end, chain_en_n, cmp_valid, cmp_hit, set_switch;
  logic loc_full, match_in_n, full_in_n, mf_enable, ff_enable, wr_op;
  logic hp_req, nf_req, page_wr_req;
  logic [W-1:0] page_addr, dev_sel;
  logic match_out_n, full_out_n, sel_hit, hp_grant, nf_grant, page_wr_grant;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  // reference state
  logic m_hit, m_on, m_mo, m_fo, m_live;

  always #2 clk = ~clk;

  casc_flag_chain #(.PAGE_W(W)) u_dut (
    .clk(clk), .rst_n(rst_n), .cyc_start(cyc_start), .cyc_end(cyc_end),
    .chain_en_n(chain_en_n), .cmp_valid(cmp_valid), .cmp_hit(cmp_hit),
    .set_switch(set_switch), .loc_full(loc_full), .match_in_n(match_in_n),
    .full_in_n(full_in_n), .mf_enable(mf_enable), .ff_enable(ff_enable),
    .page_addr(page_addr), .dev_sel(dev_sel), .wr_op(wr_op), .hp_req(hp_req),
    .nf_req(nf_req), .page_wr_req(page_wr_req), .match_out_n(match_out_n),
    .full_out_n(full_out_n), .sel_hit(sel_hit), .hp_grant(hp_grant),
    .nf_grant(nf_grant), .page_wr_grant(page_wr_grant)
  );

  function automatic logic f_match_next(input logic on, input logic mf,
                                        input logic hit, input logic mi);
    if (!on) return 1'b1;
    if (!mf) return mi;
    return (hit || !mi) ? 1'b0 : 1'b1;
  endfunction

  function automatic logic f_full_next(input logic ffe, input logic lf, input logic fi);
    if (!ffe) return fi;
    return (lf && !fi) ? 1'b0 : 1'b1;
  endfunction

  function automatic logic f_sel(input logic [W-1:0] pa, input logic [W-1:0] ds,
                                 input logic wr);
    return (ds == pa) || (wr && ds == {W{1'b1}});
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_hit <= 1'b0; m_on <= 1'b0; m_mo <= 1'b1; m_fo <= 1'b1; m_live <= 1'b0;
    end else begin
      if (cyc_start) m_on <= ~chain_en_n;
      if (set_switch) m_hit <= 1'b0;
      else if (cmp_valid) m_hit <= cmp_hit;
      if (set_switch) m_mo <= 1'b1;
      else if (cyc_end) m_mo <= f_match_next(m_on, mf_enable, m_hit, match_in_n);
      if (cyc_end) begin
        m_live <= 1'b1;
        m_fo <= f_full_next(ff_enable, loc_full, full_in_n);
      end
    end
  end

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%b expected=%b at %0t", req, act, exp, $time);
    end
  endtask

  // checks all outputs against the reference; each output tagged to its requirement
  task automatic check_all();
    logic exp_fo;
    exp_fo = m_live ? m_fo : full_in_n;
    chk(mf_enable ? (m_on ? "R3 match_out" : "R2 match_out") : "R4 match_out",
        match_out_n, m_mo);
    chk(ff_enable ? "R5 full_out" : "R6 full_out", full_out_n, exp_fo);
    chk("R8 hp_grant", hp_grant, hp_req & mf_enable & m_hit & match_in_n);
    chk("R7 nf_grant", nf_grant, nf_req & ff_enable & ~full_in_n & ~loc_full);
    chk("R9 sel_hit", sel_hit, f_sel(page_addr, dev_sel, wr_op));
    chk("R9 page_wr_grant", page_wr_grant,
        page_wr_req & f_sel(page_addr, dev_sel, wr_op) & ff_enable);
  endtask

  task automatic idle();
    cyc_start = 0; cyc_end = 0; cmp_valid = 0; set_switch = 0;
    hp_req = 0; nf_req = 0; page_wr_req = 0;
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
    check_all();
  endtask

  task automatic randomize_inputs();
    cyc_start   = ($urandom % 3) == 0;
    cyc_end     = ($urandom % 3) == 0;
    chain_en_n  = ($urandom % 3) == 0;
    cmp_valid   = ($urandom % 4) == 0;
    cmp_hit     = $urandom % 2;
    set_switch  = ($urandom % 16) == 0;
    loc_full    = $urandom % 2;
    match_in_n  = $urandom % 2;
    full_in_n   = $urandom % 2;
    mf_enable   = ($urandom % 5) != 0;
    ff_enable   = ($urandom % 5) != 0;
    wr_op       = $urandom % 2;
    hp_req      = $urandom % 2;
    nf_req      = $urandom % 2;
    page_wr_req = $urandom % 2;
    case ($urandom % 4)
      0: dev_sel = page_addr;
      1: dev_sel = {W{1'b1}};
      default: dev_sel = W'($urandom);
    endcase
  endtask

  initial begin
    #400000;
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_c0de));
    rst_n = 0;
    idle();
    chain_en_n = 1; cmp_hit = 0; loc_full = 1; match_in_n = 1; full_in_n = 0;
    mf_enable = 1; ff_enable = 1; wr_op = 0; page_addr = 16'h0003; dev_sel = 16'h0000;
    // R1: reset state, full_out follows full_in
    #5;
    chk("R1 match_out in reset", match_out_n, 1'b1);
    chk("R1 full_out follows in reset", full_out_n, 1'b0);
    full_in_n = 1; #1;
    chk("R1 full_out follows in reset", full_out_n, 1'b1);
    @(negedge clk); rst_n = 1;
    step();
    chk("R1 full_out transparent before first cycle end", full_out_n, full_in_n);

    // R11, R2, R3: local hit drives match_out low only with chain enabled
    cmp_valid = 1; cmp_hit = 1; step(); idle();
    cyc_start = 1; chain_en_n = 1; step(); idle();
    cyc_end = 1; step(); idle();
    chk("R2 chain off holds match_out high", match_out_n, 1'b1);
    cyc_start = 1; chain_en_n = 0; step(); idle();
    cyc_end = 1; step(); idle();
    chk("R3 local hit drives match_out low", match_out_n, 1'b0);
    hp_req = 1; #1;
    chk("R8 hp_grant at top of chain", hp_grant, 1'b1);
    match_in_n = 0; #1;
    chk("R8 no hp_grant when match above", hp_grant, 1'b0);
    idle(); match_in_n = 1;

    // R10: switch in the same clock as compare and cycle end
    set_switch = 1; cmp_valid = 1; cmp_hit = 1; cyc_end = 1; step(); idle();
    chk("R10 switch wins over cycle end", match_out_n, 1'b1);
    hp_req = 1; #1;
    chk("R10 switch cleared hit", hp_grant, 1'b0);
    idle();

    // R4: match flag disabled, transparent
    mf_enable = 0; match_in_n = 0; cmp_valid = 1; cmp_hit = 1; step(); idle();
    cyc_end = 1; step(); idle();
    chk("R4 match_out follows match_in", match_out_n, 1'b0);
    mf_enable = 1; match_in_n = 1;

    // R9: broadcast select on read vs write
    dev_sel = {W{1'b1}}; wr_op = 0; #1;
    chk("R9 broadcast ignored on read", sel_hit, 1'b0);
    wr_op = 1; #1;
    chk("R9 broadcast selects on write", sel_hit, 1'b1);
    page_wr_req = 1; ff_enable = 0; #1;
    chk("R6 page write blocked with full flag off", page_wr_grant, 1'b0);
    idle(); ff_enable = 1;

    // R5, R7
    full_in_n = 0; loc_full = 0; nf_req = 1; #1;
    chk("R7 next free here", nf_grant, 1'b1);
    idle();
    loc_full = 1; cyc_end = 1; step(); idle();
    chk("R5 full_out low when all full", full_out_n, 1'b0);

    for (int i = 0; i < 4000; i++) begin
      randomize_inputs();
      step();
    end
    idle();
    step();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule